// File: doc/BRIEF.md
# I2S Audio Codec Serialiser

This block connects a stereo audio codec to parallel PCM sample registers. It runs on one input clock and derives three clocks from it. The master clock runs at half the input rate. The word clock runs at the sample rate and selects the channel. The bit clock is the slowest rate that still fits a short preamble plus one sample word into each half of the word clock. Only the final bit of each slot is lengthened, so that the slot ends exactly on the next word-clock edge.

On the transmit side, the block takes the left or right parallel sample at the start of the slot and shifts it out most significant bit first. On the receive side, the block samples the codec's serial data and writes a complete word to the matching parallel output.

The master-clock rate, the sample rate, the preamble length and the word length are compile-time parameters. With the defaults (12 MHz master clock, 8 kHz sample rate, 1 preamble bit, 16-bit words), each word-clock half is 1500 input clocks. The bit-clock half period is 44 input clocks. The stretched final bit lasts 92 input clocks.

Top module: `i2s_codec_link`

## Requirements
- R1: While reset is asserted, mclk_o, lrclk_o, bclk_o, dout_o, pcm_inl_o and pcm_inr_o are all 0.
- R2: mclk_o inverts on every input clock edge, so it runs at exactly half the input clock frequency.
- R3: lrclk_o holds each level for H = MCLK_HZ/SAMPLE_HZ input clocks, which is a fixed whole number of master-clock cycles. Level 0 marks the left slot and level 1 marks the right slot.
- R4: Each bit clock half period is B = H/(2*(PRE_BITS+WORD_BITS)) input clocks, rounded down. Exactly PRE_BITS+WORD_BITS rising bclk_o edges occur in each word-clock half. Every bit except the last lasts 2*B input clocks.
- R5: The last bit of each slot lasts H-(PRE_BITS+WORD_BITS-1)*2*B input clocks (92 with the defaults), so the slot ends on the word-clock edge.
- R6: Each lrclk_o transition happens on the same input clock edge as a falling edge of bclk_o.
- R7: dout_o changes only on falling edges of bclk_o. Each slot carries PRE_BITS zero bits, then the sample, most significant bit first. The left sample goes in the lrclk_o=0 slot and the right sample in the lrclk_o=1 slot.
- R8: din_i is sampled on rising bclk_o edges. After the preamble bits, the WORD_BITS bits are taken most significant bit first. A word received in the lrclk_o=0 slot goes to pcm_inl_o, and one received in the lrclk_o=1 slot goes to pcm_inr_o.
- R9: A parallel receive output changes only once per slot, at the rising edge that samples the last word bit. Partway through a slot it still shows the previous word.
- R10: The transmit sample is captured on the word-clock edge that starts its slot. A change to pcm_outl_i or pcm_outr_i during the slot has no effect on the bits sent in that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock, twice the master-clock rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pcm_outl_i | input | WORD_BITS | Left sample to send |
| pcm_outr_i | input | WORD_BITS | Right sample to send |
| pcm_inl_o | output | WORD_BITS | Last complete left word received |
| pcm_inr_o | output | WORD_BITS | Last complete right word received |
| mclk_o | output | 1 | Codec master clock |
| lrclk_o | output | 1 | Word clock, 0 = left, 1 = right |
| bclk_o | output | 1 | Bit clock |
| dout_o | output | 1 | Serial data to the codec |
| din_i | input | 1 | Serial data from the codec |

## Verification
The hardest case is a parallel sample that changes in the middle of a slot that is already being sent. A related case is the stretched final bit, which is the only place the receive word is committed. The bench models the codec from the port waveforms alone. It follows the word-clock edges and changes the left sample halfway through a left slot, then checks that the old word still goes out. In the same half slot it checks that the receive output has not yet moved. Every slot also has its final bit length and its rising-edge count measured against the arithmetic from the parameters.

// File: rtl/i2s_codec_link.sv
module i2s_codec_link #(
  parameter int MCLK_HZ   = 12000000,
  parameter int SAMPLE_HZ = 8000,
  parameter int PRE_BITS  = 1,
  parameter int WORD_BITS = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [WORD_BITS-1:0] pcm_outl_i,
  input  logic [WORD_BITS-1:0] pcm_outr_i,
  output logic [WORD_BITS-1:0] pcm_inl_o,
  output logic [WORD_BITS-1:0] pcm_inr_o,
  output logic                 mclk_o,
  output logic                 lrclk_o,
  output logic                 bclk_o,
  output logic                 dout_o,
  input  logic                 din_i
);

  localparam int HALF_CLKS = MCLK_HZ / SAMPLE_HZ;
  localparam int SLOT_BITS = PRE_BITS + WORD_BITS;
  localparam int BIT_HALF  = HALF_CLKS / (2 * SLOT_BITS);
  localparam int CW        = $clog2(HALF_CLKS);
  localparam int NW        = $clog2(SLOT_BITS);

  localparam logic [CW-1:0] CNT_END  = CW'(HALF_CLKS - 1);
  localparam logic [CW-1:0] BIT_END  = CW'(2 * BIT_HALF - 1);
  localparam logic [CW-1:0] RISE_AT  = CW'(BIT_HALF - 1);
  localparam logic [CW-1:0] HIGH_AT  = CW'(BIT_HALF);
  localparam logic [NW-1:0] LAST_BIT = NW'(SLOT_BITS - 1);
  localparam logic [NW-1:0] WORD_AT  = NW'(PRE_BITS);

  logic [CW-1:0]        slot_cnt, phase;
  logic [NW-1:0]        bit_idx;
  logic                 lr, mclk;
  logic [SLOT_BITS-1:0] tx_sh;
  logic [WORD_BITS-1:0] rx_sh;

  wire slot_end  = slot_cnt == CNT_END;
  wire bit_end   = (phase == BIT_END) && (bit_idx != LAST_BIT);
  wire rise_next = (phase == RISE_AT) && !slot_end;

  assign mclk_o  = mclk;
  assign lrclk_o = lr;
  assign bclk_o  = phase >= HIGH_AT;
  assign dout_o  = tx_sh[SLOT_BITS-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mclk     <= 1'b0;
      lr       <= 1'b0;
      slot_cnt <= '0;
      phase    <= '0;
      bit_idx  <= '0;
      tx_sh    <= '0;
    end else begin
      mclk <= ~mclk;
      if (slot_end) begin
        slot_cnt <= '0;
        phase    <= '0;
        bit_idx  <= '0;
        lr       <= ~lr;
        tx_sh    <= SLOT_BITS'(lr ? pcm_outl_i : pcm_outr_i);
      end else begin
        slot_cnt <= slot_cnt + CW'(1);
        if (bit_end) begin
          phase   <= '0;
          bit_idx <= bit_idx + NW'(1);
          tx_sh   <= tx_sh << 1;
        end else begin
          phase <= phase + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sh     <= '0;
      pcm_inl_o <= '0;
      pcm_inr_o <= '0;
    end else if (rise_next) begin
      if (bit_idx >= WORD_AT)
        rx_sh <= {rx_sh[WORD_BITS-2:0], din_i};
      if (bit_idx == LAST_BIT) begin
        if (lr) pcm_inr_o <= {rx_sh[WORD_BITS-2:0], din_i};
        else    pcm_inl_o <= {rx_sh[WORD_BITS-2:0], din_i};
      end
    end
  end

  // R6
  lr_edge_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lrclk_o != $past(lrclk_o)) |-> $fell(bclk_o));

  // R7
  dout_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dout_o != $past(dout_o)) |-> $fell(bclk_o));

  // R5
  slot_fits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lrclk_o) |-> ($past(bit_idx) == LAST_BIT));

  // R9
  left_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pcm_inl_o != $past(pcm_inl_o)) |-> ($rose(bclk_o) && !lrclk_o));

  // R9
  right_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pcm_inr_o != $past(pcm_inr_o)) |-> ($rose(bclk_o) && lrclk_o));

  // R2
  mclk_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lrclk_o) |-> (mclk_o == $past(mclk_o, 2)));

endmodule

// File: tb/i2s_codec_link_tb_top.sv
module i2s_codec_link_tb_top;
  localparam int MCLK_HZ = 12000000, SAMPLE_HZ = 8000, PRE = 1, W = 16;
  localparam int HALF = MCLK_HZ / SAMPLE_HZ;
  localparam int SLOT = PRE + W;
  localparam int BH   = HALF / (2 * SLOT);
  localparam int LAST = HALF - (SLOT - 1) * 2 * BH;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] pcm_outl = '0, pcm_outr = '0;
  logic [W-1:0] pcm_inl, pcm_inr;
  logic mclk_o, lrclk_o, bclk_o, dout_o;
  logic din = 1'b0;

  i2s_codec_link #(.MCLK_HZ(MCLK_HZ), .SAMPLE_HZ(SAMPLE_HZ), .PRE_BITS(PRE), .WORD_BITS(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pcm_outl_i(pcm_outl), .pcm_outr_i(pcm_outr),
    .pcm_inl_o(pcm_inl), .pcm_inr_o(pcm_inr), .mclk_o(mclk_o), .lrclk_o(lrclk_o),
    .bclk_o(bclk_o), .dout_o(dout_o), .din_i(din));

  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  logic [W-1:0] rx_word [2];
  logic [W-1:0] cap [2];
  logic [W-1:0] tx_got;
  bit pm, pb, plr, pd, armed;
  int cyc, lr_t, last_fall, rises, j, bad_period, mclk_bad, dout_bad, pre_bad;

  function automatic logic din_for(input logic ch, input int jj);
    if (jj < PRE) return 1'b0;
    return rx_word[ch][W-1-(jj-PRE)];
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; armed = 0; rises = 0; j = 0; tx_got = '0;
      bad_period = 0; mclk_bad = 0; dout_bad = 0; pre_bad = 0;
    end else begin
      bit fall, rise;
      cyc++;
      fall = pb && !bclk_o;
      rise = !pb && bclk_o;
      if (mclk_o == pm) mclk_bad++;
      if (dout_o != pd && !fall) dout_bad++;
      if (lrclk_o != plr) begin
        check(fall, "R6 bclk fall at word edge", bclk_o, 0);
        if (armed) begin
          check(cyc - lr_t == HALF, "R3 word half length", cyc - lr_t, HALF);
          check(rises == SLOT, "R4 rising edges per slot", rises, SLOT);
          check(bad_period == 0, "R4 bit period", bad_period, 0);
          check(cyc - last_fall == LAST, "R5 stretched last bit", cyc - last_fall, LAST);
          check(mclk_bad == 0, "R2 mclk toggle", mclk_bad, 0);
          check(dout_bad == 0 && pre_bad == 0, "R7 dout timing and preamble", dout_bad + pre_bad, 0);
          cap[plr] = tx_got;
        end
        armed = 1; lr_t = cyc; last_fall = cyc; rises = 0; j = 0; tx_got = '0;
        bad_period = 0; mclk_bad = 0; dout_bad = 0; pre_bad = 0;
        din = din_for(lrclk_o, 0);
      end else if (fall) begin
        if (cyc - last_fall != 2 * BH) bad_period++;
        last_fall = cyc;
        j++;
        din = din_for(lrclk_o, j);
      end
      if (rise) begin
        rises++;
        if (j >= PRE) tx_got[W-1-(j-PRE)] = dout_o;
        else if (dout_o) pre_bad++;
      end
    end
    pm = mclk_o; pb = bclk_o; plr = lrclk_o; pd = dout_o;
  end

  task automatic wait_lr(input logic v);
    do @(negedge clk); while (lrclk_o !== v);
  endtask

  logic [W-1:0] prev_l = '0, prev_r = '0;

  task automatic run_frame(input logic [W-1:0] l, input logic [W-1:0] r,
                           input logic [W-1:0] il, input logic [W-1:0] ir, input bit mid_change);
    wait_lr(1'b1);
    pcm_outl = l; rx_word[0] = il;
    wait_lr(1'b0);
    pcm_outr = r; rx_word[1] = ir;
    repeat (HALF / 2) @(negedge clk);
    check(pcm_inl == prev_l, "R9 left output holds mid-slot", pcm_inl, prev_l);
    if (mid_change) pcm_outl = ~l;
    wait_lr(1'b1);
    @(negedge clk);
    check(cap[0] == l, mid_change ? "R10 mid-slot change ignored" : "R7 left word sent", cap[0], l);
    check(pcm_inl == il, "R8 left word received", pcm_inl, il);
    prev_l = il;
    repeat (HALF / 2) @(negedge clk);
    check(pcm_inr == prev_r, "R9 right output holds mid-slot", pcm_inr, prev_r);
    wait_lr(1'b0);
    @(negedge clk);
    check(cap[1] == r, "R7 right word sent", cap[1], r);
    check(pcm_inr == ir, "R8 right word received", pcm_inr, ir);
    prev_r = ir;
  endtask

  task automatic check_reset();
    repeat (5) @(negedge clk);
    check({mclk_o, lrclk_o, bclk_o, dout_o} == 4'b0, "R1 clocks and data low", {mclk_o, lrclk_o, bclk_o, dout_o}, 0);
    check(pcm_inl == '0, "R1 left output clear", pcm_inl, 0);
    check(pcm_inr == '0, "R1 right output clear", pcm_inr, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    rx_word[0] = '0; rx_word[1] = '0;
    check_reset();
    wait_lr(1'b1);
    run_frame(16'hA5A5, 16'h5A5A, 16'h1234, 16'hFEDC, 1'b0);
    run_frame(16'hFFFF, 16'h0000, 16'h8001, 16'h7FFE, 1'b0);
    run_frame(16'h0001, 16'h8000, 16'hFFFF, 16'h0000, 1'b0);
    run_frame(16'h3C96, 16'hC369, 16'h0F0F, 16'hF0F0, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule